// File: doc/BRIEF.md
# Bit-Plane Raster Operation Unit

This unit owns one bit plane of a multi-plane frame buffer and applies 16-bit raster operations to the word it is handed. A sequencer elsewhere presents one operation per clock: a register load, a bit-sliced (Z-axis) register load, or a raster cycle. A raster cycle is one of two source-read cycles or the read/modify/write cycle. Every cycle picks one entry from one of two banks of operand control registers. That entry decides where the local memory word and the word on the shared instruction/data bus are stored, and whether this plane drives its memory word onto the bus.

In the read/modify/write cycle the unit forms a function of the destination word and the source register. That result chooses between the foreground and background registers bit by bit. The chosen word is then merged into memory under a compound mask built from mask1, mask2 and an edge mask that comes from outside. A chip-select input lets a sequencer address any subset of the planes. A unit whose select is clear takes no part in loads or cycles.

Top module: `plane_rop_unit`

## Requirements
- R1: After reset every register holds zero, `fill_value` is zero, and a read/modify/write cycle writes back `mem_rdata` unchanged because both masks are zero.
- R2: With `op`=1 (plain load) and `sel`=1, `id_in` is stored in the register at `reg_addr`. Addresses 0..7 are control entries (bank*4+entry), 8..11 are function registers 0..3, 12 source, 13 mask1, 14 mask2, 15 foreground, 16 background, 17 fill. Any other address is ignored.
- R3: With `op`=2 (Z-axis load), bit PLANE_ID of `id_in` is copied into all 16 bits of the addressed register. This applies only to source, foreground, background and fill. A Z-axis load to any other address changes nothing.
- R4: With `sel`=0 no register changes, `mem_we`, `id_oe` and `route_err` stay low.
- R5: A control entry routes data by two fields: bits [1:0] give the destination of bus data and bits [3:2] give the destination of local memory data. Code 0 means none, 1 means source, 2 means both masks and 3 means mask2 only. The routed values are written at the clock edge that ends the cycle.
- R6: When bit 4 of the active control entry is set, the unit raises `id_oe` and drives `mem_rdata` on `id_out` during that cycle.
- R7: With `op`=3 (cycle), the active entry is bank `bank`, entry `cyc_entry`. Entry 0 is source cycle 1, entry 1 is source cycle 2 and entry 2 is read/modify/write. Entry 3 does nothing.
- R8: In read/modify/write, function register bits [3:0] form a truth table. Bit v = table[{dest,src}]. The new word is (v AND fg) OR (NOT v AND bg).
- R9: The write mask is mask1 AND mask2 AND `edge_mask`. Mask1 is inverted when bit 4 of the chosen function register is set, and mask2 when bit 5 is set. Bits where the mask is 0 keep `mem_rdata`.
- R10: With `ptb`=1, entries 0 and 1 also perform the read/modify/write and assert `mem_we`.
- R11: If bus and local data target a common register, `route_err` is high in that cycle and the bus value is stored.
- R12: The read/modify/write uses register values from before the cycle, even when the same cycle routes new data into them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 2 | 0 idle, 1 load, 2 Z-axis load, 3 raster cycle |
| sel | input | 1 | Chip select for this plane |
| reg_addr | input | 5 | Register address for loads |
| cyc_entry | input | 2 | Control entry used by the cycle |
| bank | input | 1 | Control bank used by the cycle |
| ptb | input | 1 | Processor-to-bitmap transfer flag |
| lf_sel | input | 2 | Function register index |
| edge_mask | input | 16 | Edge mask from the sequencer |
| id_in | input | 16 | Shared bus data sampled by this unit |
| mem_rdata | input | 16 | Bitmap word read this cycle |
| mem_we | output | 1 | Write strobe for the bitmap word |
| mem_wdata | output | 16 | Merged word to write |
| id_oe | output | 1 | Drive enable onto the shared bus |
| id_out | output | 16 | Word driven onto the shared bus |
| route_err | output | 1 | Bus and local data aimed at one register |
| fill_value | output | 16 | Fill register contents for the scroll path |

## Verification
A single read/modify/write cycle can both compute a merged word from the source register and route a new value into that register. This happens in a processor-to-bitmap cycle on entry 1 whose local field targets the source. The bench arms this case with a known source value and then presents a different memory word. It expects the written word to reflect the old source, and a following cycle to show the new source. A second overlap is a routing conflict: the bus and local data both target the source in one cycle. This is judged by `route_err` and by the source value a later cycle exposes.

// File: rtl/rop_pkg.sv
package rop_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_ZLOAD = 2'd2,
        OP_CYCLE = 2'd3
    } rop_op_e;

    // control entry layout
    localparam int CTL_W    = 5;
    localparam int BUS_LSB  = 0;
    localparam int LOC_LSB  = 2;
    localparam int SEND_BIT = 4;

    // function register layout
    localparam int LF_W      = 6;
    localparam int LF_INV_M1 = 4;
    localparam int LF_INV_M2 = 5;

    // control entry roles
    localparam int ENT_SRC1 = 0;
    localparam int ENT_SRC2 = 1;
    localparam int ENT_RMW  = 2;

    // destination code -> {mask2, mask1, source}
    function automatic logic [2:0] dst_targets(input logic [1:0] code);
        case (code)
            2'd1:    return 3'b001;
            2'd2:    return 3'b110;
            2'd3:    return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/rop_route.sv
module rop_route #(
    parameter int DATA_W = 16
) (
    input  logic [1:0]        bus_dst,
    input  logic [1:0]        loc_dst,
    input  logic [DATA_W-1:0] bus_word,
    input  logic [DATA_W-1:0] loc_word,
    input  logic [DATA_W-1:0] src_q,
    input  logic [DATA_W-1:0] m1_q,
    input  logic [DATA_W-1:0] m2_q,
    output logic [DATA_W-1:0] src_d,
    output logic [DATA_W-1:0] m1_d,
    output logic [DATA_W-1:0] m2_d,
    output logic              conflict
);
    import rop_pkg::*;

    logic [2:0] bus_t;
    logic [2:0] loc_t;

    always_comb begin
        bus_t    = dst_targets(bus_dst);
        loc_t    = dst_targets(loc_dst);
        src_d    = bus_t[0] ? bus_word : (loc_t[0] ? loc_word : src_q);
        m1_d     = bus_t[1] ? bus_word : (loc_t[1] ? loc_word : m1_q);
        m2_d     = bus_t[2] ? bus_word : (loc_t[2] ? loc_word : m2_q);
        conflict = |(bus_t & loc_t);
    end

endmodule

// File: rtl/rop_bit.sv
module rop_bit (
    input  logic [3:0] tt,
    input  logic       dst,
    input  logic       src,
    input  logic       fg,
    input  logic       bg,
    input  logic       msk,
    output logic       q
);
    logic v;

    always_comb begin
        v = tt[{dst, src}];
        q = msk ? (v ? fg : bg) : dst;
    end

endmodule

// File: rtl/plane_rop_unit.sv
module plane_rop_unit #(
    parameter int DATA_W      = 16,
    parameter int PLANE_ID    = 0,
    parameter int NUM_BANKS   = 2,
    parameter int CTL_ENTRIES = 4,
    parameter int NUM_LF      = 4,
    parameter int ADDR_W      = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     op,
    input  logic                           sel,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic [$clog2(CTL_ENTRIES)-1:0] cyc_entry,
    input  logic [$clog2(NUM_BANKS)-1:0]   bank,
    input  logic                           ptb,
    input  logic [$clog2(NUM_LF)-1:0]      lf_sel,
    input  logic [DATA_W-1:0]              edge_mask,
    input  logic [DATA_W-1:0]              id_in,
    input  logic [DATA_W-1:0]              mem_rdata,
    output logic                           mem_we,
    output logic [DATA_W-1:0]              mem_wdata,
    output logic                           id_oe,
    output logic [DATA_W-1:0]              id_out,
    output logic                           route_err,
    output logic [DATA_W-1:0]              fill_value
);
    import rop_pkg::*;

    localparam int CTL_N      = NUM_BANKS * CTL_ENTRIES;
    localparam int CTL_IDX_W  = $clog2(CTL_N);
    localparam int A_LF0      = CTL_N;
    localparam int A_SRC      = CTL_N + NUM_LF;
    localparam int A_M1       = A_SRC + 1;
    localparam int A_M2       = A_SRC + 2;
    localparam int A_FG       = A_SRC + 3;
    localparam int A_BG       = A_SRC + 4;
    localparam int A_FILL     = A_SRC + 5;

    typedef struct packed {
        logic [CTL_N-1:0][CTL_W-1:0] ctl;
        logic [NUM_LF-1:0][LF_W-1:0] lf;
        logic [DATA_W-1:0]           src;
        logic [DATA_W-1:0]           m1;
        logic [DATA_W-1:0]           m2;
        logic [DATA_W-1:0]           fg;
        logic [DATA_W-1:0]           bg;
        logic [DATA_W-1:0]           fill;
    } regs_t;

    regs_t                regs_d, regs_q;
    rop_op_e              op_e;
    logic [CTL_IDX_W-1:0] ctl_idx;
    logic [CTL_W-1:0]     cur_ctl;
    logic [LF_W-1:0]      cur_lf;
    logic                 cyc_live;
    logic [DATA_W-1:0]    wmask;
    logic [DATA_W-1:0]    zword;
    logic [DATA_W-1:0]    rt_src, rt_m1, rt_m2;
    logic                 rt_conflict;

    assign op_e     = rop_op_e'(op);
    assign ctl_idx  = CTL_IDX_W'(int'(bank) * CTL_ENTRIES + int'(cyc_entry));
    assign cur_ctl  = regs_q.ctl[ctl_idx];
    assign cur_lf   = regs_q.lf[lf_sel];
    assign cyc_live = (op_e == OP_CYCLE) && sel && (int'(cyc_entry) <= ENT_RMW);
    assign zword    = {DATA_W{id_in[PLANE_ID]}};
    assign wmask    = (regs_q.m1 ^ {DATA_W{cur_lf[LF_INV_M1]}})
                    & (regs_q.m2 ^ {DATA_W{cur_lf[LF_INV_M2]}})
                    & edge_mask;

    rop_route #(.DATA_W(DATA_W)) u_route (
        .bus_dst  (cur_ctl[BUS_LSB +: 2]),
        .loc_dst  (cur_ctl[LOC_LSB +: 2]),
        .bus_word (id_in),
        .loc_word (mem_rdata),
        .src_q    (regs_q.src),
        .m1_q     (regs_q.m1),
        .m2_q     (regs_q.m2),
        .src_d    (rt_src),
        .m1_d     (rt_m1),
        .m2_d     (rt_m2),
        .conflict (rt_conflict)
    );

    for (genvar b = 0; b < DATA_W; b++) begin : g_slice
        rop_bit u_bit (
            .tt  (cur_lf[3:0]),
            .dst (mem_rdata[b]),
            .src (regs_q.src[b]),
            .fg  (regs_q.fg[b]),
            .bg  (regs_q.bg[b]),
            .msk (wmask[b]),
            .q   (mem_wdata[b])
        );
    end

    always_comb begin
        regs_d    = regs_q;
        mem_we    = 1'b0;
        id_oe     = 1'b0;
        route_err = 1'b0;
        if (sel) begin
            case (op_e)
                OP_LOAD: begin
                    for (int i = 0; i < CTL_N; i++)
                        if (reg_addr == ADDR_W'(i)) regs_d.ctl[i] = id_in[CTL_W-1:0];
                    for (int i = 0; i < NUM_LF; i++)
                        if (reg_addr == ADDR_W'(A_LF0 + i)) regs_d.lf[i] = id_in[LF_W-1:0];
                    if (reg_addr == ADDR_W'(A_SRC))  regs_d.src  = id_in;
                    if (reg_addr == ADDR_W'(A_M1))   regs_d.m1   = id_in;
                    if (reg_addr == ADDR_W'(A_M2))   regs_d.m2   = id_in;
                    if (reg_addr == ADDR_W'(A_FG))   regs_d.fg   = id_in;
                    if (reg_addr == ADDR_W'(A_BG))   regs_d.bg   = id_in;
                    if (reg_addr == ADDR_W'(A_FILL)) regs_d.fill = id_in;
                end
                OP_ZLOAD: begin
                    if (reg_addr == ADDR_W'(A_SRC))  regs_d.src  = zword;
                    if (reg_addr == ADDR_W'(A_FG))   regs_d.fg   = zword;
                    if (reg_addr == ADDR_W'(A_BG))   regs_d.bg   = zword;
                    if (reg_addr == ADDR_W'(A_FILL)) regs_d.fill = zword;
                end
                OP_CYCLE: begin
                    if (cyc_live) begin
                        regs_d.src = rt_src;
                        regs_d.m1  = rt_m1;
                        regs_d.m2  = rt_m2;
                        route_err  = rt_conflict;
                        id_oe      = cur_ctl[SEND_BIT];
                        mem_we     = (int'(cyc_entry) == ENT_RMW) || ptb;
                    end
                end
                default: ;
            endcase
        end
    end

    assign id_out     = id_oe ? mem_rdata : '0;
    assign fill_value = regs_q.fill;

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

endmodule

module rop_unit_chk #(
    parameter int DATA_W  = 16,
    parameter int ENT_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        op,
    input logic              sel,
    input logic [ENT_W-1:0]  cyc_entry,
    input logic              ptb,
    input logic [DATA_W-1:0] edge_mask,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              id_oe,
    input logic              route_err
);
    // R4
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (!mem_we && !id_oe && !route_err));

    // R9
    edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (((mem_wdata ^ mem_rdata) & ~edge_mask) == '0));

    // R10
    write_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (op == 2'd3 && (int'(cyc_entry) == 2 || ptb)));

    // R7
    unused_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd3 && int'(cyc_entry) == 3) |-> (!mem_we && !id_oe && !route_err));

    // R11
    err_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_err |-> (op == 2'd3 && sel));

    // R6
    drive_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_oe |-> (op == 2'd3 && sel));
endmodule

bind plane_rop_unit rop_unit_chk #(.DATA_W(DATA_W), .ENT_W($clog2(CTL_ENTRIES))) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .sel       (sel),
    .cyc_entry (cyc_entry),
    .ptb       (ptb),
    .edge_mask (edge_mask),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .id_oe     (id_oe),
    .route_err (route_err)
);

// File: tb/sim_plane_rop_unit.sv
`timescale 1ns/1ps
module sim_plane_rop_unit;

    localparam logic [1:0] LD = 2'd1, ZL = 2'd2, CY = 2'd3;
    localparam int NV = 37;

    typedef struct packed {
        logic [1:0]  op;
        logic        sel;
        logic [4:0]  addr;
        logic [1:0]  ent;
        logic        bank;
        logic        ptb;
        logic [1:0]  lf;
        logic [15:0] edge_m;
        logic [15:0] id;
        logic [15:0] md;
        logic        x_we;
        logic [15:0] x_wd;
        logic        x_oe;
        logic        x_err;
        logic [3:0]  req;
    } vec_t;

    // op sel addr ent bank ptb lf edge id md | we wd oe err req
    localparam vec_t VECS [NV] = '{
        '{CY,1'b1,5'd0, 2'd2,1'b0,1'b0,2'd0,16'hFFFF,16'h0000,16'h1234, 1'b1,16'h1234,1'b0,1'b0,4'd1},  // R1
        '{LD,1'b1,5'd8, 2'd0,1'b0,1'b0,2'd0,16'h0000,16'h000A,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd2},  // R2
        '{LD,1'b1,5'd13,2'd0,1'b0,1'b0,2'd0,16'h0000,16'hFFFF,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd2},
        '{LD,1'b1,5'd14,2'd0,1'b0,1'b0,2'd0,16'h0000,16'hFFFF,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd2},
        '{LD,1'b1,5'd15,2'd0,1'b0,1'b0,2'd0,16'h0000,16'hFFFF,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd2},
        '{LD,1'b1,5'd12,2'd0,1'b0,1'b0,2'd0,16'h0000,16'h5A3C,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd2},
        '{CY,1'b1,5'd0, 2'd2,1'b0,1'b0,2'd0,16'hFFFF,16'h0000,16'h0F0F, 1'b1,16'h5A3C,1'b0,1'b0,4'd8},  // R8
        '{CY,1'b1,5'd0, 2'd2,1'b0,1'b0,2'd0,16'h00FF,16'h0000,16'hFFFF, 1'b1,16'hFF3C,1'b0,1'b0,4'd9},  // R9
        '{LD,1'b1,5'd9, 2'd0,1'b0,1'b0,2'd0,16'h0000,16'h0016,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd2},
        '{LD,1'b1,5'd13,2'd0,1'b0,1'b0,2'd0,16'h0000,16'hFF00,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd2},
        '{CY,1'b1,5'd0, 2'd2,1'b0,1'b0,2'd1,16'hFFFF,16'h0000,16'h1111, 1'b1,16'h112D,1'b0,1'b0,4'd9},  // R9 inverted mask1
        '{ZL,1'b1,5'd16,2'd0,1'b0,1'b0,2'd0,16'h0000,16'h0020,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd3},  // R3
        '{ZL,1'b1,5'd15,2'd0,1'b0,1'b0,2'd0,16'h0000,16'hFFDF,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd3},
        '{ZL,1'b1,5'd13,2'd0,1'b0,1'b0,2'd0,16'h0000,16'hFFFF,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd3},
        '{CY,1'b1,5'd0, 2'd2,1'b0,1'b0,2'd0,16'hFFFF,16'h0000,16'h0000, 1'b1,16'hA500,1'b0,1'b0,4'd3},  // R3 result
        '{LD,1'b0,5'd12,2'd0,1'b0,1'b0,2'd0,16'h0000,16'h0000,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd4},  // R4
        '{CY,1'b0,5'd0, 2'd2,1'b0,1'b0,2'd0,16'hFFFF,16'h0000,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd4},
        '{CY,1'b1,5'd0, 2'd2,1'b0,1'b0,2'd0,16'hFFFF,16'h0000,16'h0000, 1'b1,16'hA500,1'b0,1'b0,4'd4},
        '{LD,1'b1,5'd15,2'd0,1'b0,1'b0,2'd0,16'h0000,16'hFFFF,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd2},
        '{LD,1'b1,5'd16,2'd0,1'b0,1'b0,2'd0,16'h0000,16'h0000,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd2},
        '{LD,1'b1,5'd13,2'd0,1'b0,1'b0,2'd0,16'h0000,16'hFFFF,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd2},
        '{LD,1'b1,5'd4, 2'd0,1'b0,1'b0,2'd0,16'h0000,16'h0001,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd5},  // R5
        '{CY,1'b1,5'd0, 2'd0,1'b1,1'b0,2'd0,16'hFFFF,16'h00C3,16'h9999, 1'b0,16'h0000,1'b0,1'b0,4'd5},
        '{CY,1'b1,5'd0, 2'd2,1'b0,1'b0,2'd0,16'hFFFF,16'h0000,16'h0000, 1'b1,16'h00C3,1'b0,1'b0,4'd5},
        '{LD,1'b1,5'd5, 2'd0,1'b0,1'b0,2'd0,16'h0000,16'h001C,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd6},  // R6
        '{CY,1'b1,5'd0, 2'd1,1'b1,1'b0,2'd0,16'hFFFF,16'h0FF0,16'h0FF0, 1'b0,16'h0000,1'b1,1'b0,4'd6},
        '{CY,1'b1,5'd0, 2'd2,1'b0,1'b0,2'd0,16'hFFFF,16'h0000,16'h0000, 1'b1,16'h00C0,1'b0,1'b0,4'd6},
        '{LD,1'b1,5'd0, 2'd0,1'b0,1'b0,2'd0,16'h0000,16'h0005,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd11}, // R11
        '{CY,1'b1,5'd0, 2'd0,1'b0,1'b0,2'd0,16'hFFFF,16'h1357,16'h2468, 1'b0,16'h0000,1'b0,1'b1,4'd11},
        '{LD,1'b1,5'd14,2'd0,1'b0,1'b0,2'd0,16'h0000,16'hFFFF,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd2},
        '{CY,1'b1,5'd0, 2'd2,1'b0,1'b0,2'd0,16'hFFFF,16'h0000,16'h0000, 1'b1,16'h1357,1'b0,1'b0,4'd11},
        '{LD,1'b1,5'd1, 2'd0,1'b0,1'b0,2'd0,16'h0000,16'h0004,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd12}, // R12
        '{CY,1'b1,5'd0, 2'd1,1'b0,1'b1,2'd0,16'hFFFF,16'h0000,16'h00FF, 1'b1,16'h1357,1'b0,1'b0,4'd10}, // R10
        '{CY,1'b1,5'd0, 2'd2,1'b0,1'b0,2'd0,16'hFFFF,16'h0000,16'h0000, 1'b1,16'h00FF,1'b0,1'b0,4'd12},
        '{LD,1'b1,5'd3, 2'd0,1'b0,1'b0,2'd0,16'h0000,16'h0001,16'h0000, 1'b0,16'h0000,1'b0,1'b0,4'd7},  // R7
        '{CY,1'b1,5'd0, 2'd3,1'b0,1'b1,2'd0,16'hFFFF,16'hAAAA,16'h5555, 1'b0,16'h0000,1'b0,1'b0,4'd7},
        '{CY,1'b1,5'd0, 2'd2,1'b0,1'b0,2'd0,16'hFFFF,16'h0000,16'h0000, 1'b1,16'h00FF,1'b0,1'b0,4'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        sel = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [1:0]  cyc_entry = '0;
    logic        bank = 1'b0;
    logic        ptb = 1'b0;
    logic [1:0]  lf_sel = '0;
    logic [15:0] edge_mask = '0;
    logic [15:0] id_in = '0;
    logic [15:0] mem_rdata = '0;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic        id_oe;
    logic [15:0] id_out;
    logic        route_err;
    logic [15:0] fill_value;

    int applied = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    plane_rop_unit #(.PLANE_ID(5)) u0 (
        .clk(clk), .rst_n(rst_n), .op(op), .sel(sel), .reg_addr(reg_addr),
        .cyc_entry(cyc_entry), .bank(bank), .ptb(ptb), .lf_sel(lf_sel),
        .edge_mask(edge_mask), .id_in(id_in), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .id_oe(id_oe), .id_out(id_out),
        .route_err(route_err), .fill_value(fill_value)
    );

    task automatic drive(input vec_t v);
        @(negedge clk);
        op = v.op; sel = v.sel; reg_addr = v.addr; cyc_entry = v.ent;
        bank = v.bank; ptb = v.ptb; lf_sel = v.lf; edge_mask = v.edge_m;
        id_in = v.id; mem_rdata = v.md;
        #1;
    endtask

    task automatic check_vec(input int n, input vec_t v);
        logic ok;
        ok = (mem_we == v.x_we) && (id_oe == v.x_oe) && (route_err == v.x_err);
        if (v.x_we && mem_wdata != v.x_wd) ok = 1'b0;
        if (v.x_oe && id_out != v.md) ok = 1'b0;
        applied++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d vec %0d: we/wd/oe/out/err got %b/%h/%b/%h/%b want %b/%h/%b/%h/%b",
                     v.req, n, mem_we, mem_wdata, id_oe, id_out, route_err,
                     v.x_we, v.x_wd, v.x_oe, v.md, v.x_err);
        end
    endtask

    task automatic check_val(input string req, input logic [15:0] got, input logic [15:0] exp);
        applied++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic vec_t idle_vec();
        return '0;
    endfunction

    function automatic vec_t mk(input logic [1:0] o, input logic [4:0] a,
                                input logic [15:0] d, input logic [15:0] m);
        vec_t v;
        v = '0;
        v.op = o; v.sel = 1'b1; v.addr = a; v.id = d; v.md = m;
        v.ent = 2'd2; v.edge_m = 16'hFFFF;
        return v;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check_vec(i, VECS[i]);
        end
        // R3 Z-axis load of fill, plane 5 bit set then clear
        drive(mk(ZL, 5'd17, 16'h0020, 16'h0));
        @(negedge clk); check_val("R3 fill set", fill_value, 16'hFFFF);
        drive(mk(ZL, 5'd17, 16'hFFDF, 16'h0));
        @(negedge clk); check_val("R3 fill clear", fill_value, 16'h0000);
        // R2 plain load of fill; R2 unmapped address ignored
        drive(mk(LD, 5'd17, 16'h00C3, 16'h0));
        drive(mk(LD, 5'd25, 16'h7777, 16'h0));
        @(negedge clk); check_val("R2 fill load", fill_value, 16'h00C3);
        // R1 reset mid-run clears everything
        drive(idle_vec());
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1 check_val("R1 fill after reset", fill_value, 16'h0000);
        drive(mk(CY, 5'd0, 16'h0, 16'hBEEF));
        check_val("R1 rmw after reset", mem_wdata, 16'hBEEF);
        check_val("R1 write strobe", {15'd0, mem_we}, 16'h0001);
        drive(idle_vec());
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            applied++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

endmodule